// File: doc/BRIEF.md
# Audio Event Interrupt Flag Controller

This block collects seven single-cycle event pulses from an audio front end (short-circuit clear, jack detect, short-circuit, headphone ramp-up done, headphone ramp-down done, gain-up done and gain-down done). It turns them into one interrupt line. Each event sets a sticky flag that software reads back and clears by writing ones. A mask register keeps chosen sources off the interrupt line. A 2-bit form field sets how the line signals: an active-high level, an active-low level, a high pulse or a low pulse.

Flags latch whether or not their source is masked, so software can poll masked events. In the level forms the line follows the OR of the unmasked flags. In the pulse forms a pulse of `PULSE_W` cycles is emitted each time an unmasked flag goes from clear to set. Software reaches the flag, mask and control words through three write strobes that share one write-data bus. All three words are always visible on read-back ports.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After synchronous reset the flags read 0x00, the mask reads 0x7F (all sources blocked), the form field reads 0 and the interrupt output is low.
- R2: A pulse on event input bit n sets flag bit n on the next clock edge. The flag stays set through any number of cycles without a flag write that clears it.
- R3: A flag write clears each flag bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0x7F clears every flag.
- R4: When an event and a write-one-to-clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: Flags latch on events even when their mask bit is 1. A source whose mask bit is 1 never drives the interrupt output.
- R6: With form 0 the interrupt output is high exactly when some flag bit is set and its mask bit is 0.
- R7: With form 1 the interrupt output is the inverse of the form 0 level: low while an unmasked flag is set, high otherwise.
- R8: With form 2 the output idles low. An event that sets a previously clear, unmasked flag makes the output high for exactly `PULSE_W` cycles, starting the cycle after the event. An event on an already set flag or on a masked source gives no pulse.
- R9: With form 3 the output idles high and drops low for exactly `PULSE_W` cycles under the same trigger conditions as R8.
- R10: A mask write stores write-data bits 6:0 and ignores bit 7. A control write stores write-data bits 7:6 as the form field and ignores bits 5:0.
- R11: Flag and mask bit positions are fixed: bit 6 short-circuit clear, bit 5 jack, bit 4 short-circuit, bit 3 ramp-up done, bit 2 ramp-down done, bit 1 gain-up done, bit 0 gain-down done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | Single-cycle event pulses, bit order per R11 |
| flag_wr_en | input | 1 | Write-one-to-clear strobe for the flag word |
| mask_wr_en | input | 1 | Write strobe for the mask word |
| ctrl_wr_en | input | 1 | Write strobe for the control word (form in bits 7:6) |
| wr_data | input | 8 | Shared write data |
| flag_rd | output | 7 | Current sticky flags |
| mask_rd | output | 7 | Current mask |
| form_rd | output | 2 | Current interrupt form code |
| irq_out | output | 1 | Interrupt output |

## Verification
A vector table drives the level form through a sequence of mask settings, events and clears. The sequence separates three cases: a masked flag that must latch but stay silent, a clear that hits one bit while an event sets another, and an event and a clear colliding on the same bit. Directed steps then switch through the inverted level and both pulse forms. They count the exact pulse width and confirm that re-hitting a set flag or hitting a masked source gives no pulse. Writes with the ignored data bits set show that the mask and form fields take only their own bits. A single event on the ramp-up input pins the flag bit order.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int NUM_SRC = 7;

    // Source bit positions (software-visible order)
    localparam int SRC_GAIN_DN  = 0;
    localparam int SRC_GAIN_UP  = 1;
    localparam int SRC_RAMP_DN  = 2;
    localparam int SRC_RAMP_UP  = 3;
    localparam int SRC_SHORT    = 4;
    localparam int SRC_JACK     = 5;
    localparam int SRC_SHORT_CL = 6;

    localparam int FORM_LSB = 6;

    typedef enum logic [1:0] {
        FORM_LVL_HI = 2'd0,
        FORM_LVL_LO = 2'd1,
        FORM_PLS_HI = 2'd2,
        FORM_PLS_LO = 2'd3
    } irq_form_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        irq_form_e          form;
    } irq_cfg_t;

    localparam irq_cfg_t CFG_RESET = '{mask: '1, form: FORM_LVL_HI};

    function automatic logic form_is_pulse(irq_form_e f);
        return (f == FORM_PLS_HI) || (f == FORM_PLS_LO);
    endfunction

    function automatic logic form_is_low(irq_form_e f);
        return (f == FORM_LVL_LO) || (f == FORM_PLS_LO);
    endfunction

endpackage

// File: rtl/airq_flag_bank.sv
module airq_flag_bank
    import audio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] flags,
    output logic [N-1:0] new_set
);

    logic [N-1:0] flags_q;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic clr_hit;
            assign clr_hit = clr_en & clr_bits[i];
            always_ff @(posedge clk) begin
                if (rst)
                    flags_q[i] <= 1'b0;
                else if (evt[i])
                    flags_q[i] <= 1'b1;   // event beats a same-cycle clear
                else if (clr_hit)
                    flags_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign flags   = flags_q;
    assign new_set = evt & ~flags_q;

endmodule

// File: rtl/airq_cfg_regs.sv
module airq_cfg_regs
    import audio_irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mask_wr_en,
    input  logic          ctrl_wr_en,
    input  logic [DW-1:0] wr_data,
    output irq_cfg_t      cfg
);

    irq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (mask_wr_en)
                cfg_q.mask <= wr_data[N-1:0];
            if (ctrl_wr_en)
                cfg_q.form <= irq_form_e'(wr_data[FORM_LSB+1:FORM_LSB]);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/airq_out_shaper.sv
module airq_out_shaper
    import audio_irq_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  irq_form_e form,
    input  logic      pending,
    input  logic      trig,
    output logic      irq
);

    localparam int CW = $clog2(PULSE_W + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

    logic [CW-1:0] cnt_q;
    logic          busy;
    logic          raw;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (trig && form_is_pulse(form))
            cnt_q <= LOAD;
        else if (busy)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        raw = form_is_pulse(form) ? busy : pending;
        irq = form_is_low(form) ? ~raw : raw;
    end

endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
    import audio_irq_pkg::*;
#(
    parameter int PULSE_W = 4,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               flag_wr_en,
    input  logic               mask_wr_en,
    input  logic               ctrl_wr_en,
    input  logic [DW-1:0]      wr_data,
    output logic [NUM_SRC-1:0] flag_rd,
    output logic [NUM_SRC-1:0] mask_rd,
    output logic [1:0]         form_rd,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] new_set;
    irq_cfg_t           cfg;
    logic               pending;
    logic               trig;

    airq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .clr_en   (flag_wr_en),
        .clr_bits (wr_data[NUM_SRC-1:0]),
        .flags    (flags),
        .new_set  (new_set)
    );

    airq_cfg_regs #(.N(NUM_SRC), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .mask_wr_en (mask_wr_en),
        .ctrl_wr_en (ctrl_wr_en),
        .wr_data    (wr_data),
        .cfg        (cfg)
    );

    assign pending = |(flags & ~cfg.mask);
    assign trig    = |(new_set & ~cfg.mask);

    airq_out_shaper #(.PULSE_W(PULSE_W)) u_shape (
        .clk     (clk),
        .rst     (rst),
        .form    (cfg.form),
        .pending (pending),
        .trig    (trig),
        .irq     (irq_out)
    );

    assign flag_rd = flags;
    assign mask_rd = cfg.mask;
    assign form_rd = cfg.form;

endmodule

// File: rtl/airq_checker.sv
module airq_checker
    import audio_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               flag_wr_en,
    input logic               mask_wr_en,
    input logic               ctrl_wr_en,
    input logic [DW-1:0]      wr_data,
    input logic [NUM_SRC-1:0] flag_rd,
    input logic [NUM_SRC-1:0] mask_rd,
    input logic [1:0]         form_rd,
    input logic               irq_out
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (flag_rd == '0 && mask_rd == '1 && form_rd == 2'd0));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((flag_rd & $past(evt_pulse)) == $past(evt_pulse)));

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_wr_en |=> ((flag_rd & $past(flag_rd)) == $past(flag_rd)));

    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        flag_wr_en |=> ((flag_rd & $past(wr_data[NUM_SRC-1:0] & ~evt_pulse)) == '0));

    a_r6_level_high: assert property (@(posedge clk) disable iff (rst)
        (form_rd == 2'd0) |-> (irq_out == |(flag_rd & ~mask_rd)));

    a_r7_level_low: assert property (@(posedge clk) disable iff (rst)
        (form_rd == 2'd1) |-> (irq_out == ~|(flag_rd & ~mask_rd)));

    a_r10_mask_write: assert property (@(posedge clk) disable iff (rst)
        mask_wr_en |=> (mask_rd == $past(wr_data[NUM_SRC-1:0])));

    a_r10_form_write: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr_en |=> (form_rd == $past(wr_data[DW-1:DW-2])));

endmodule

bind audio_irq_ctrl airq_checker #(.DW(DW)) u_chk (.*);

// File: tb/audio_irq_ctrl_test.sv
module audio_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;

    localparam int B_GAIN_DN = 0;
    localparam int B_GAIN_UP = 1;
    localparam int B_RAMP_DN = 2;
    localparam int B_RAMP_UP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] evt_pulse = '0;
    logic       flag_wr_en = 1'b0;
    logic       mask_wr_en = 1'b0;
    logic       ctrl_wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] flag_rd;
    logic [6:0] mask_rd;
    logic [1:0] form_rd;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_irq_ctrl #(.PULSE_W(PW)) uut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
        .flag_wr_en(flag_wr_en), .mask_wr_en(mask_wr_en), .ctrl_wr_en(ctrl_wr_en),
        .wr_data(wr_data), .flag_rd(flag_rd), .mask_rd(mask_rd),
        .form_rd(form_rd), .irq_out(irq_out)
    );

    // {mask, evt, clr, exp_flags, exp_irq}, form 0, walked in order
    localparam int NV = 7;
    localparam logic [28:0] VEC [NV] = '{
        {7'h7F, 7'h01, 7'h00, 7'h01, 1'b0},  // R5 masked latches, silent
        {7'h7E, 7'h00, 7'h00, 7'h01, 1'b1},  // R6 unmask drives level
        {7'h7E, 7'h40, 7'h01, 7'h40, 1'b0},  // R3 clear one, R5 new one masked
        {7'h3F, 7'h00, 7'h00, 7'h40, 1'b1},  // R6
        {7'h3F, 7'h20, 7'h40, 7'h20, 1'b0},  // R3
        {7'h00, 7'h04, 7'h04, 7'h24, 1'b1},  // R4 event beats clear
        {7'h00, 7'h00, 7'h7F, 7'h00, 1'b0}   // R3 clear all
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_mask(logic [7:0] d);
        mask_wr_en = 1'b1; wr_data = d; tick(); mask_wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        ctrl_wr_en = 1'b1; wr_data = d; tick(); ctrl_wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clr_flags(logic [7:0] d);
        flag_wr_en = 1'b1; wr_data = d; tick(); flag_wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic fire(logic [6:0] e);
        evt_pulse = e; tick(); evt_pulse = '0;
    endtask

    // counts samples (current plus next n-1) where irq_out equals lvl
    task automatic count_lvl(logic lvl, int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            if (irq_out === lvl) c++;
            if (k < n - 1) tick();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int c;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R1 reset values
        check("R1 flags", flag_rd, 7'h00);
        check("R1 mask", mask_rd, 7'h7F);
        check("R1 form", form_rd, 2'd0);
        check("R1 irq", irq_out, 1'b0);

        // Table walk, form 0
        for (int v = 0; v < NV; v++) begin
            logic [6:0] m, e, cl, ef;
            logic ei;
            {m, e, cl, ef, ei} = VEC[v];
            wr_mask({1'b0, m});
            evt_pulse = e;
            flag_wr_en = (cl != 0);
            wr_data = {1'b0, cl};
            tick();
            evt_pulse = '0; flag_wr_en = 1'b0; wr_data = '0;
            check($sformatf("R3/R4/R5 vec%0d flags", v), flag_rd, ef);
            check($sformatf("R6 vec%0d irq", v), irq_out, ei);
        end

        // R2 sticky over idle cycles
        fire(7'h10);
        repeat (5) tick();
        check("R2 sticky", flag_rd, 7'h10);
        clr_flags(8'h7F);

        // R11 ramp-up done lands on bit 3
        fire(7'(1 << B_RAMP_UP));
        check("R11 ramp-up bit", flag_rd, 7'h08);
        clr_flags(8'h7F);

        // R7 inverted level
        wr_ctrl(8'h40);
        check("R7 idle high", irq_out, 1'b1);
        fire(7'(1 << B_GAIN_UP));
        check("R7 asserted low", irq_out, 1'b0);
        clr_flags(8'h7F);
        check("R7 released", irq_out, 1'b1);

        // R8 high pulse
        wr_ctrl(8'h80);
        check("R8 idle low", irq_out, 1'b0);
        fire(7'(1 << B_GAIN_UP));
        count_lvl(1'b1, PW + 4, c);
        check("R8 pulse width", c, PW);
        fire(7'(1 << B_GAIN_UP));          // already set: no pulse
        check("R8 no pulse on set flag", irq_out, 1'b0);
        wr_mask(8'h04);
        fire(7'(1 << B_RAMP_DN));          // masked: no pulse, flag latches
        check("R8 no pulse when masked", irq_out, 1'b0);
        check("R5 masked flag latched", flag_rd, 7'h06);

        // R9 low pulse
        wr_ctrl(8'hC0);
        check("R9 idle high", irq_out, 1'b1);
        fire(7'(1 << B_GAIN_DN));
        count_lvl(1'b0, PW + 4, c);
        check("R9 pulse width", c, PW);

        // R10 ignored bits
        wr_ctrl(8'h3F);
        check("R10 form low bits ignored", form_rd, 2'd0);
        wr_mask(8'h80);
        check("R10 mask bit7 ignored", mask_rd, 7'h00);
        check("R6 level after unmask", irq_out, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule